// File: doc/BRIEF.md
# Sector-Synchronised Pulse-Density Sequencer

This block sets which of the three mains phases conduct in each switching cycle of a three-phase to single-phase resonant converter. It works in blocks of a fixed number of switching cycles. In every block two of the phases follow nested pulse-density patterns. One is the phase with the largest current, called the dominant phase. The other is the remaining outer phase, called the side phase. The density of each pattern is worked out from the sector and from the block number inside the sector. The third phase is the one whose current crosses zero in the middle of the sector. Its pattern is the dominant pattern with the side pattern removed. As a result, in every cycle the dominant phase conducts exactly when one of the other two does, so the three input currents sum to zero.

The sequencer follows the mains through a single-cycle sector strobe that carries a sector number. A new sector is accepted only in the last few blocks of the current sector. It takes effect at the next block boundary. If the last block of a sector ends before any strobe has arrived, that last block is played again. There is no data stream and no back-pressure. The cycle tick and the strobe are one-cycle pulses that are consumed in the cycle they are high. All outputs follow from registered state and change only on clock edges.

Top module: `pdm_sector_seq`

## Requirements
- R1: After reset, `active` is low, `ph_en` is 000, `circ` is low, `blk_idx` is 0 and `cur_sec` is 0. Ticks do not change this until a valid strobe arrives.
- R2: While idle, a strobe with `sec_num` in 0..5 makes `active` high on the next edge, with `cur_sec` equal to `sec_num`, `blk_idx` at 0 and the cycle position at 0.
- R3: The cycle position advances only on edges where `cyc_tick` is high. After 16 ticks, `blk_idx` steps by one. Without a tick, `blk_idx`, `cur_sec` and `ph_en` hold.
- R4: Let r be the 4-bit bit-reversal of the cycle position p. A pattern of density d is on at position p if and only if r < d, so every pattern is contained in every pattern of higher density.
- R5: Let h = 1 when the block b is 18 or more, and h = 0 otherwise. Let j = 35-b when h = 1, and j = b otherwise. The dominant density is 12 + floor(5j/18). The side density is the dominant density minus floor((17-j)/2).
- R6: Bits 0, 1 and 2 of `ph_en` are phases A, B and C. With k = 2*sector + h, the dominant phase is B, A or C for ((k+1)/2) mod 3 equal to 0, 1 or 2. The zero-crossing phase is C, B or A for sector mod 3 equal to 0, 1 or 2. The side phase is the one left over. The zero-crossing phase is on when the dominant pattern is on and the side pattern is off.
- R7: In every cycle, the number of set bits in `ph_en` is 0 or 2.
- R8: `circ` is high exactly when `active` is high and `ph_en` is 000.
- R9: While running, a strobe that arrives when `blk_idx` is below 34 has no effect.
- R10: A valid strobe that arrives when `blk_idx` is 34 or 35 is held until the tick that ends the current block. On that tick, `cur_sec` takes the strobed sector and `blk_idx` returns to 0. If several strobes arrive, the last one wins.
- R11: When block 35 ends with no strobe held, `blk_idx` stays at 35 and that block's pattern repeats.
- R12: A strobe with `sec_num` of 6 or 7 is ignored, both while idle and while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One pulse per switching cycle |
| sec_stb | input | 1 | Sector-change strobe |
| sec_num | input | 3 | Sector number that goes with the strobe |
| ph_en | output | 3 | Conduction enables for phases A, B and C |
| circ | output | 1 | Free-wheel cycle: running with no phase enabled |
| active | output | 1 | Sequencer has locked to a sector |
| blk_idx | output | 6 | Block number within the sector |
| cur_sec | output | 3 | Sector in use |

## Verification
The hardest condition to reach is a sector change that is held across several cycles inside the arming window, including a second strobe that overrides the first. To get there, the stimulus counts exactly 34 blocks plus a few cycles of ticks. It then strobes with no tick and watches `cur_sec` stay put until the closing tick of the block. Repetition of the last block needs a run longer than a full sector with no strobe, so one test overruns by 40 ticks. Every phase role is covered by spot vectors across all six sectors and both half sectors, and one whole sector is swept cycle by cycle against a model built from the requirements.

// File: rtl/pdm_seq_pkg.sv
package pdm_seq_pkg;
  localparam int NUM_PHASES = 3;
  localparam int NUM_SECTORS = 6;
  localparam int SEC_W = 3;

  // Phase codes: 0 = A, 1 = B, 2 = C
  typedef logic [1:0] phase_t;

  localparam phase_t PH_A = 2'd0;
  localparam phase_t PH_B = 2'd1;
  localparam phase_t PH_C = 2'd2;

  // Largest-current phase for a given sector and half sector
  function automatic phase_t dominant_of(input int sec, input int half);
    int k;
    k = 2 * sec + half;
    case (((k + 1) / 2) % 3)
      0:       return PH_B;
      1:       return PH_A;
      default: return PH_C;
    endcase
  endfunction

  // Phase whose current crosses zero at mid-sector
  function automatic phase_t crossing_of(input int sec);
    case (sec % 3)
      0:       return PH_C;
      1:       return PH_B;
      default: return PH_A;
    endcase
  endfunction
endpackage

// File: rtl/pdm_seq_ctrl.sv
module pdm_seq_ctrl #(
  parameter int CYC_PER_BLK = 16,
  parameter int BLK_PER_SEC = 36,
  parameter int ARM_BLKS    = 2,
  localparam int POS_W = $clog2(CYC_PER_BLK),
  localparam int BLK_W = $clog2(BLK_PER_SEC)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             stb,
  input  logic [pdm_seq_pkg::SEC_W-1:0]    stb_sec,
  output logic                             running,
  output logic [pdm_seq_pkg::SEC_W-1:0]    sec_q,
  output logic [BLK_W-1:0]                 blk_q,
  output logic [POS_W-1:0]                 pos_q
);
  import pdm_seq_pkg::*;

  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(CYC_PER_BLK - 1);
  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(BLK_PER_SEC - 1);
  localparam logic [BLK_W-1:0] ARM_FROM  = BLK_W'(BLK_PER_SEC - ARM_BLKS);
  localparam logic [SEC_W-1:0] SEC_LIMIT = SEC_W'(NUM_SECTORS);

  logic             pend_q;
  logic [SEC_W-1:0] pend_sec_q;
  logic             stb_ok, armed, take, pend_any, blk_end;
  logic [SEC_W-1:0] pend_pick;

  assign stb_ok    = stb && (stb_sec < SEC_LIMIT);
  assign armed     = running && (blk_q >= ARM_FROM);
  assign take      = stb_ok && armed;
  assign pend_any  = pend_q || take;
  assign pend_pick = take ? stb_sec : pend_sec_q;
  assign blk_end   = running && tick && (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      sec_q      <= '0;
      blk_q      <= '0;
      pos_q      <= '0;
      pend_q     <= 1'b0;
      pend_sec_q <= '0;
    end else if (!running) begin
      if (stb_ok) begin
        running <= 1'b1;
        sec_q   <= stb_sec;
        blk_q   <= '0;
        pos_q   <= '0;
        pend_q  <= 1'b0;
      end
    end else if (blk_end) begin
      pos_q <= '0;
      if (pend_any) begin
        sec_q  <= pend_pick;
        blk_q  <= '0;
        pend_q <= 1'b0;
      end else if (blk_q != LAST_BLK) begin
        blk_q <= blk_q + 1'b1;
      end
    end else begin
      if (tick) pos_q <= pos_q + 1'b1;
      pend_q     <= pend_any;
      pend_sec_q <= pend_pick;
    end
  end
endmodule

// File: rtl/pdm_seq_lookup.sv
module pdm_seq_lookup #(
  parameter int CYC_PER_BLK = 16,
  parameter int BLK_PER_SEC = 36,
  localparam int BLK_W  = $clog2(BLK_PER_SEC),
  localparam int DENS_W = $clog2(CYC_PER_BLK + 1),
  localparam int HALF   = BLK_PER_SEC / 2,
  localparam int DMIN   = (CYC_PER_BLK * 3) / 4
) (
  input  logic [pdm_seq_pkg::SEC_W-1:0] sec,
  input  logic [BLK_W-1:0]              blk,
  output pdm_seq_pkg::phase_t           dom_ph,
  output pdm_seq_pkg::phase_t           side_ph,
  output pdm_seq_pkg::phase_t           zero_ph,
  output logic [DENS_W-1:0]             dens_hi,
  output logic [DENS_W-1:0]             dens_lo
);
  import pdm_seq_pkg::*;

  int b_i, half_i, j_i, hi_i, gap_i, lo_i, s_i;

  always_comb begin
    b_i    = int'(blk);
    s_i    = int'(sec);
    half_i = (b_i >= HALF) ? 1 : 0;
    j_i    = (half_i == 1) ? (BLK_PER_SEC - 1 - b_i) : b_i;
    hi_i   = DMIN + (j_i * (CYC_PER_BLK - DMIN + 1)) / HALF;
    if (hi_i > CYC_PER_BLK) hi_i = CYC_PER_BLK;
    gap_i  = (HALF - 1 - j_i) / 2;
    lo_i   = (hi_i > gap_i) ? (hi_i - gap_i) : 0;
    dens_hi = DENS_W'(hi_i);
    dens_lo = DENS_W'(lo_i);
    dom_ph  = dominant_of(s_i, half_i);
    zero_ph = crossing_of(s_i);
    side_ph = phase_t'(3 - int'(dom_ph) - int'(zero_ph));
  end
endmodule

// File: rtl/pdm_seq_pattern.sv
module pdm_seq_pattern #(
  parameter int CYC_PER_BLK = 16,
  localparam int POS_W  = $clog2(CYC_PER_BLK),
  localparam int DENS_W = $clog2(CYC_PER_BLK + 1)
) (
  input  logic                run,
  input  logic [POS_W-1:0]    pos,
  input  pdm_seq_pkg::phase_t dom_ph,
  input  pdm_seq_pkg::phase_t side_ph,
  input  pdm_seq_pkg::phase_t zero_ph,
  input  logic [DENS_W-1:0]   dens_hi,
  input  logic [DENS_W-1:0]   dens_lo,
  output logic [2:0]          en,
  output logic                idle_cyc
);
  import pdm_seq_pkg::*;

  logic [POS_W-1:0] rank;
  logic             hit_hi, hit_lo;

  // Bit-reversed position spreads pulses and keeps densities nested
  for (genvar i = 0; i < POS_W; i++) begin : g_rev
    assign rank[i] = pos[POS_W-1-i];
  end

  assign hit_hi = {1'b0, rank} < dens_hi;
  assign hit_lo = {1'b0, rank} < dens_lo;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    assign en[g] = run && (
        ((dom_ph  == phase_t'(g)) && hit_hi) ||
        ((side_ph == phase_t'(g)) && hit_lo) ||
        ((zero_ph == phase_t'(g)) && hit_hi && !hit_lo));
  end

  assign idle_cyc = run && (en == 3'b000);
endmodule

// File: rtl/pdm_sector_seq.sv
module pdm_sector_seq #(
  parameter int CYC_PER_BLK = 16,
  parameter int BLK_PER_SEC = 36,
  parameter int ARM_BLKS    = 2,
  localparam int POS_W  = $clog2(CYC_PER_BLK),
  localparam int BLK_W  = $clog2(BLK_PER_SEC),
  localparam int DENS_W = $clog2(CYC_PER_BLK + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cyc_tick,
  input  logic                          sec_stb,
  input  logic [pdm_seq_pkg::SEC_W-1:0] sec_num,
  output logic [2:0]                    ph_en,
  output logic                          circ,
  output logic                          active,
  output logic [BLK_W-1:0]              blk_idx,
  output logic [pdm_seq_pkg::SEC_W-1:0] cur_sec
);
  import pdm_seq_pkg::*;

  logic [POS_W-1:0]  pos;
  phase_t            dom_ph, side_ph, zero_ph;
  logic [DENS_W-1:0] dens_hi, dens_lo;

  pdm_seq_ctrl #(
    .CYC_PER_BLK(CYC_PER_BLK), .BLK_PER_SEC(BLK_PER_SEC), .ARM_BLKS(ARM_BLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .stb(sec_stb), .stb_sec(sec_num),
    .running(active), .sec_q(cur_sec), .blk_q(blk_idx), .pos_q(pos)
  );

  pdm_seq_lookup #(
    .CYC_PER_BLK(CYC_PER_BLK), .BLK_PER_SEC(BLK_PER_SEC)
  ) u_lookup (
    .sec(cur_sec), .blk(blk_idx), .dom_ph(dom_ph), .side_ph(side_ph),
    .zero_ph(zero_ph), .dens_hi(dens_hi), .dens_lo(dens_lo)
  );

  pdm_seq_pattern #(.CYC_PER_BLK(CYC_PER_BLK)) u_pattern (
    .run(active), .pos(pos), .dom_ph(dom_ph), .side_ph(side_ph),
    .zero_ph(zero_ph), .dens_hi(dens_hi), .dens_lo(dens_lo),
    .en(ph_en), .idle_cyc(circ)
  );
endmodule

// File: rtl/pdm_sector_seq_chk.sv
module pdm_sector_seq_chk #(
  parameter int BLK_PER_SEC = 36,
  parameter int ARM_BLKS    = 2,
  localparam int BLK_W = $clog2(BLK_PER_SEC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_tick,
  input logic             sec_stb,
  input logic [2:0]       sec_num,
  input logic [2:0]       ph_en,
  input logic             circ,
  input logic             active,
  input logic [BLK_W-1:0] blk_idx,
  input logic [2:0]       cur_sec
);
  localparam logic [BLK_W-1:0] ARM_FROM = BLK_W'(BLK_PER_SEC - ARM_BLKS);

  // R7
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ph_en) == 0) || ($countones(ph_en) == 2));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (ph_en == 3'b000) && !circ);

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cyc_tick) |=> $stable(blk_idx) && $stable(cur_sec));

  // R9
  early_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sec_stb && (blk_idx < ARM_FROM)) |=> $stable(cur_sec));

  // R10
  switch_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(cur_sec)) |-> (blk_idx == '0));

  // R12
  bad_sector_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && sec_stb && (sec_num > 3'd5)) |=> !active);
endmodule

bind pdm_sector_seq pdm_sector_seq_chk #(
  .BLK_PER_SEC(BLK_PER_SEC), .ARM_BLKS(ARM_BLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .sec_stb(sec_stb),
  .sec_num(sec_num), .ph_en(ph_en), .circ(circ), .active(active),
  .blk_idx(blk_idx), .cur_sec(cur_sec)
);

// File: tb/pdm_sector_seq_test.sv
module pdm_sector_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       sec_stb = 1'b0;
  logic [2:0] sec_num = 3'd0;
  logic [2:0] ph_en;
  logic       circ, active;
  logic [5:0] blk_idx;
  logic [2:0] cur_sec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdm_sector_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .sec_stb(sec_stb),
    .sec_num(sec_num), .ph_en(ph_en), .circ(circ), .active(active),
    .blk_idx(blk_idx), .cur_sec(cur_sec)
  );

  // {sector, block, position, expected enables C B A}
  localparam logic [15:0] VEC [8] = '{
    {3'd0, 6'd0,  4'd0, 3'b011},
    {3'd0, 6'd0,  4'd1, 3'b110},
    {3'd0, 6'd0,  4'd3, 3'b000},
    {3'd0, 6'd18, 4'd0, 3'b011},
    {3'd1, 6'd0,  4'd1, 3'b011},
    {3'd3, 6'd5,  4'd2, 3'b011},
    {3'd5, 6'd35, 4'd7, 3'b000},
    {3'd2, 6'd20, 4'd5, 3'b110}
  };

  function automatic int rev4(int p);
    return ((p & 1) << 3) | ((p & 2) << 1) | ((p & 4) >> 1) | ((p & 8) >> 3);
  endfunction

  function automatic logic [2:0] model_en(int s, int b, int p);
    int h, j, hi, lo, k, dm, zr, sd, r;
    logic [2:0] e;
    h  = (b >= 18) ? 1 : 0;
    j  = (h == 1) ? 35 - b : b;
    hi = 12 + (j * 5) / 18;
    lo = hi - (17 - j) / 2;
    k  = 2 * s + h;
    case (((k + 1) / 2) % 3) 0: dm = 1; 1: dm = 0; default: dm = 2; endcase
    case (s % 3) 0: zr = 2; 1: zr = 1; default: zr = 0; endcase
    sd = 3 - dm - zr;
    r  = rev4(p);
    e  = 3'b000;
    if (r < hi) e[dm] = 1'b1;
    if (r < lo) e[sd] = 1'b1;
    if ((r < hi) && !(r < lo)) e[zr] = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic s, input logic [2:0] n);
    @(negedge clk);
    cyc_tick = t; sec_stb = s; sec_num = n;
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc_tick = 1'b0; sec_stb = 1'b0; sec_num = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Vector table walk: R4, R5, R6, R8
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vs, ve;
      logic [5:0] vb;
      logic [3:0] vp;
      {vs, vb, vp, ve} = VEC[v];
      do_reset();
      step(1'b0, 1'b1, vs);
      ticks(int'(vb) * 16 + int'(vp));
      check(ph_en == ve, "R4 R5 R6 pattern", ph_en, ve);
      check(blk_idx == vb, "R3 block", blk_idx, vb);
      check(circ == (ve == 3'b000), "R8 circ", circ, ve == 3'b000);
    end

    // R1 reset state and ticks while idle
    do_reset();
    @(posedge clk); #1;
    check(!active && ph_en == 0 && !circ && blk_idx == 0 && cur_sec == 0,
          "R1 reset", {active, ph_en, circ}, 0);
    ticks(5);
    check(!active && ph_en == 0, "R1 idle ticks", active, 0);

    // R12 invalid sectors while idle
    step(1'b0, 1'b1, 3'd6);
    check(!active, "R12 sector 6 idle", active, 0);
    step(1'b0, 1'b1, 3'd7);
    check(!active, "R12 sector 7 idle", active, 0);

    // R2 start
    step(1'b0, 1'b1, 3'd2);
    check(active && cur_sec == 2 && blk_idx == 0, "R2 start", cur_sec, 2);
    check(ph_en == model_en(2, 0, 0), "R2 position zero", ph_en, model_en(2, 0, 0));

    // R3 hold without tick, then one block of ticks
    ticks(3);
    step(1'b0, 1'b0, 3'd0);
    step(1'b0, 1'b0, 3'd0);
    check(ph_en == model_en(2, 0, 3) && blk_idx == 0, "R3 hold", ph_en, model_en(2, 0, 3));
    ticks(13);
    check(blk_idx == 1, "R3 block step", blk_idx, 1);

    // R9 early strobe ignored
    do_reset();
    step(1'b0, 1'b1, 3'd5);
    ticks(10 * 16 + 3);
    step(1'b0, 1'b1, 3'd2);
    ticks(13);
    check(cur_sec == 5 && blk_idx == 11, "R9 early strobe", cur_sec, 5);

    // R10 deferred switch, last strobe wins
    do_reset();
    step(1'b0, 1'b1, 3'd0);
    ticks(34 * 16 + 5);
    step(1'b0, 1'b1, 3'd3);
    check(cur_sec == 0 && blk_idx == 34, "R10 no mid-block switch", cur_sec, 0);
    ticks(10);
    check(cur_sec == 0, "R10 held to block end", cur_sec, 0);
    step(1'b0, 1'b1, 3'd4);
    ticks(1);
    check(cur_sec == 4 && blk_idx == 0, "R10 switch at boundary", cur_sec, 4);
    check(ph_en == model_en(4, 0, 0), "R10 new pattern", ph_en, model_en(4, 0, 0));

    // R11 final block repeats
    do_reset();
    step(1'b0, 1'b1, 3'd1);
    ticks(36 * 16 + 40);
    check(blk_idx == 35 && cur_sec == 1, "R11 repeat block", blk_idx, 35);
    check(ph_en == model_en(1, 35, 8), "R11 repeat pattern", ph_en, model_en(1, 35, 8));

    // R12 invalid sector in arming window
    do_reset();
    step(1'b0, 1'b1, 3'd0);
    ticks(34 * 16);
    step(1'b0, 1'b1, 3'd7);
    ticks(16);
    check(cur_sec == 0 && blk_idx == 35, "R12 sector 7 running", cur_sec, 0);

    // Full sweep of one sector: R4 R5 R6 R7 R8
    do_reset();
    step(1'b0, 1'b1, 3'd4);
    for (int i = 0; i < 576; i++) begin
      logic [2:0] e;
      e = model_en(4, i / 16, i % 16);
      check(ph_en == e, "R6 sweep", ph_en, e);
      check(blk_idx == 6'(i / 16), "R3 sweep block", blk_idx, i / 16);
      check(circ == (e == 3'b000), "R8 sweep circ", circ, e == 3'b000);
      check($countones(ph_en) == 0 || $countones(ph_en) == 2, "R7 pair", ph_en, 0);
      ticks(1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule